// File: doc/BRIEF.md
# Global 64-bit Timer with Compare Event

This block is a system-wide time base. A 64-bit up-counter advances by one on every clock while it is running, and a single 64-bit compare unit raises an event when the counter reaches a programmed value. In periodic mode the compare unit adds a programmed 32-bit step to its own value on each hit, so events repeat at a fixed spacing without any software action. A hit sets a pending flag. The interrupt line is that flag gated by an enable bit.

The block sits behind a plain 32-bit register port, with one write strobe and a combinational read of the addressed word. Writes to the counter halves, the compare halves, the step and the control word model a slow timer clock domain: they reach the live register only `LAT` cycles after the bus write, and then set a per-register done bit that software clears by writing 1. The interrupt-enable word and the clear-on-write-1 words act on the next edge. Reading the counter low word latches nothing, so software reads the counter as high, low, high and retries if the two high reads differ.

Top module: `gtc_timer`

## Requirements
- R1: After reset all registers read zero and `irq` is low.
- R2: A write to a delayed register (counter low 0x00, counter high 0x04, compare low 0x10, compare high 0x14, step 0x18, control 0x1C) is captured on the edge where `wr_en` is high. It takes effect, and sets its done bit, on the `LAT`-th edge after that. It is not visible before then. Counter done bits live at 0x08 (bit 0 low, bit 1 high). The other done bits live at 0x28 (bit 0 compare low, bit 1 compare high, bit 2 step, bit 3 control).
- R3: Writing 1 to a done bit clears it on the next edge. Writing 0 leaves it set. A done bit set on the same edge wins over a clear.
- R4: A counter half written while the counter is stopped (control bit 0 clear) reads back the written value and holds it.
- R5: While control bit 0 is set the 64-bit counter advances by one per cycle, carrying from the low word into the high word. Reading the low word does not latch or alter it.
- R6: A hit happens in a cycle where the counter is running, compare is enabled (control bit 1), and the counter equals the compare value. The hit sets the pending bit (0x20 bit 0). With auto-step off (control bit 2 clear), no further hit occurs.
- R7: Writing 1 to the pending bit clears it. Writing 0 leaves it. `irq` is high exactly when pending and the enable bit (0x24 bit 0) are both set.
- R8: With auto-step on, each hit adds the step value to the compare value. The compare value read back is then the smallest value base+n*step that is not below the counter.
- R9: Writes to the interrupt enable at 0x24, and the clear-on-write-1 words, act on the next edge without the write delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Compare interrupt, pending AND enable |

## Verification
A wrong write-delay stage count moves the done bit and the new register value by one or more cycles, and the read sampled on the exact cycle shows it. A counter that drops a carry or stalls shows as a wrong difference between two reads a few cycles apart, or as a wrong high word after the low word wraps. A compare unit that misses a hit, fires twice, or adds the step wrongly leaves the pending bit or the read-back compare value off within a few tens of cycles of the programmed hit.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 8'h04;
  localparam logic [ADDR_W-1:0] A_CNT_WST = 8'h08;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 8'h10;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 8'h14;
  localparam logic [ADDR_W-1:0] A_STEP    = 8'h18;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h1C;
  localparam logic [ADDR_W-1:0] A_PEND    = 8'h20;
  localparam logic [ADDR_W-1:0] A_IEN     = 8'h24;
  localparam logic [ADDR_W-1:0] A_WST     = 8'h28;

  // control word bit positions
  localparam int C_RUN  = 0;
  localparam int C_CMP  = 1;
  localparam int C_AUTO = 2;

  // registers whose writes pass through the slow-domain delay line
  function automatic logic is_delayed(input logic [ADDR_W-1:0] a);
    return (a == A_CNT_LO) || (a == A_CNT_HI) || (a == A_CMP_LO) ||
           (a == A_CMP_HI) || (a == A_STEP)   || (a == A_CTRL);
  endfunction

  // merge a loaded half into a 2*DATA_W value
  function automatic logic [2*DATA_W-1:0] load_half(
      input logic [2*DATA_W-1:0] cur, input logic lo, input logic hi,
      input logic [DATA_W-1:0] d);
    return {hi ? d : cur[2*DATA_W-1:DATA_W], lo ? d : cur[DATA_W-1:0]};
  endfunction

  function automatic logic [2*DATA_W-1:0] advance(
      input logic [2*DATA_W-1:0] cur, input logic [DATA_W-1:0] step);
    return cur + {{DATA_W{1'b0}}, step};
  endfunction

  // sticky bits: set wins over clear
  function automatic logic [DATA_W-1:0] sticky(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] set,
      input logic [DATA_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/gtc_wr_pipe.sv
module gtc_wr_pipe #(
  parameter int LAT = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [AW-1:0] in_a,
  input  logic [DW-1:0] in_d,
  output logic          out_v,
  output logic [AW-1:0] out_a,
  output logic [DW-1:0] out_d
);
  localparam int STAGES = (LAT < 1) ? 1 : LAT;

  generate
    if (LAT == 0) begin : g_pass
      assign out_v = in_v;
      assign out_a = in_a;
      assign out_d = in_d;
    end else begin : g_line
      logic          v_q [STAGES];
      logic [AW-1:0] a_q [STAGES];
      logic [DW-1:0] d_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            v_q[s] <= 1'b0;
            a_q[s] <= '0;
            d_q[s] <= '0;
          end else if (s == 0) begin
            v_q[s] <= in_v;
            a_q[s] <= in_a;
            d_q[s] <= in_d;
          end else begin
            v_q[s] <= v_q[s-1];
            a_q[s] <= a_q[s-1];
            d_q[s] <= d_q[s-1];
          end
        end
      end
      assign out_v = v_q[STAGES-1];
      assign out_a = a_q[STAGES-1];
      assign out_d = d_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [HW-1:0]   ld_d,
  output logic [2*HW-1:0] cnt
);
  import gtc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (ld_lo || ld_hi) cnt <= load_half(cnt, ld_lo, ld_hi, ld_d);
    else if (run)            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gtc_comparator.sv
module gtc_comparator #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            en,
  input  logic            auto_en,
  input  logic [HW-1:0]   step,
  input  logic [2*HW-1:0] cnt,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [HW-1:0]   ld_d,
  output logic [2*HW-1:0] cmp,
  output logic            hit
);
  import gtc_pkg::*;

  assign hit = run && en && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n)              cmp <= '0;
    else if (ld_lo || ld_hi) cmp <= load_half(cmp, ld_lo, ld_hi, ld_d);
    else if (hit && auto_en) cmp <= advance(cmp, step);
  end
endmodule

// File: rtl/gtc_timer.sv
module gtc_timer #(
  parameter int LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  import gtc_pkg::*;
  localparam int HW = DATA_W;

  // delayed write path
  logic          land_v;
  logic [7:0]    land_a;
  logic [HW-1:0] land_d;

  gtc_wr_pipe #(.LAT(LAT), .AW(ADDR_W), .DW(HW)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_v(wr_en && is_delayed(addr)), .in_a(addr), .in_d(wdata),
    .out_v(land_v), .out_a(land_a), .out_d(land_d)
  );

  logic ld_cnt_lo, ld_cnt_hi, ld_cmp_lo, ld_cmp_hi, ld_step, ld_ctrl;
  assign ld_cnt_lo = land_v && (land_a == A_CNT_LO);
  assign ld_cnt_hi = land_v && (land_a == A_CNT_HI);
  assign ld_cmp_lo = land_v && (land_a == A_CMP_LO);
  assign ld_cmp_hi = land_v && (land_a == A_CMP_HI);
  assign ld_step   = land_v && (land_a == A_STEP);
  assign ld_ctrl   = land_v && (land_a == A_CTRL);

  // immediate write decode
  logic wr_cwst, wr_rwst, wr_pend, wr_ien;
  assign wr_cwst = wr_en && (addr == A_CNT_WST);
  assign wr_rwst = wr_en && (addr == A_WST);
  assign wr_pend = wr_en && (addr == A_PEND);
  assign wr_ien  = wr_en && (addr == A_IEN);

  // control and step
  logic [2:0]    ctrl;
  logic [HW-1:0] step;
  logic          run, cmp_en, auto_en;
  assign run     = ctrl[C_RUN];
  assign cmp_en  = ctrl[C_CMP];
  assign auto_en = ctrl[C_AUTO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      step <= '0;
    end else begin
      if (ld_ctrl) ctrl <= land_d[2:0];
      if (ld_step) step <= land_d;
    end
  end

  // counter and compare
  logic [2*HW-1:0] cnt, cmp;
  logic            match_ev;

  gtc_counter #(.HW(HW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_lo(ld_cnt_lo), .ld_hi(ld_cnt_hi), .ld_d(land_d), .cnt(cnt)
  );

  gtc_comparator #(.HW(HW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .run(run), .en(cmp_en), .auto_en(auto_en),
    .step(step), .cnt(cnt),
    .ld_lo(ld_cmp_lo), .ld_hi(ld_cmp_hi), .ld_d(land_d),
    .cmp(cmp), .hit(match_ev)
  );

  // done bits, pending, enable
  logic [HW-1:0] cnt_wst, reg_wst, cwst_set, rwst_set;
  logic          pend, ien;

  assign cwst_set = {{(HW-2){1'b0}}, ld_cnt_hi, ld_cnt_lo};
  assign rwst_set = {{(HW-4){1'b0}}, ld_ctrl, ld_step, ld_cmp_hi, ld_cmp_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_wst <= '0;
      reg_wst <= '0;
      pend    <= 1'b0;
      ien     <= 1'b0;
    end else begin
      cnt_wst <= sticky(cnt_wst, cwst_set, wr_cwst ? wdata : '0);
      reg_wst <= sticky(reg_wst, rwst_set, wr_rwst ? wdata : '0);
      pend    <= (pend && !(wr_pend && wdata[0])) || match_ev;
      if (wr_ien) ien <= wdata[0];
    end
  end

  logic wst_any;
  assign wst_any = (cnt_wst != '0) || (reg_wst != '0);

  assign irq = pend & ien;

  always_comb begin
    unique case (addr)
      A_CNT_LO:  rdata = cnt[HW-1:0];
      A_CNT_HI:  rdata = cnt[2*HW-1:HW];
      A_CNT_WST: rdata = cnt_wst;
      A_CMP_LO:  rdata = cmp[HW-1:0];
      A_CMP_HI:  rdata = cmp[2*HW-1:HW];
      A_STEP:    rdata = step;
      A_CTRL:    rdata = {{(HW-3){1'b0}}, ctrl};
      A_PEND:    rdata = {{(HW-1){1'b0}}, pend};
      A_IEN:     rdata = {{(HW-1){1'b0}}, ien};
      A_WST:     rdata = reg_wst;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gtc_timer_chk.sv
module gtc_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        land_v,
  input logic        run,
  input logic        auto_en,
  input logic        match_ev,
  input logic        pend,
  input logic        irq,
  input logic        wst_any,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic [31:0] step
);
  assert_done_after_land_R2: assert property (@(posedge clk) disable iff (!rst_n)
    land_v |=> wst_any);

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !land_v) |=> $stable(cnt));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !land_v) |=> (cnt == $past(cnt) + 64'd1));

  assert_hit_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> pend);

  assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  assert_auto_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && auto_en && !land_v) |=> (cmp == $past(cmp) + {32'd0, $past(step)}));
endmodule

bind gtc_timer gtc_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .land_v(land_v), .run(run), .auto_en(auto_en),
  .match_ev(match_ev), .pend(pend), .irq(irq), .wst_any(wst_any),
  .cnt(cnt), .cmp(cmp), .step(step)
);

// File: tb/gtc_timer_tb.sv
module gtc_timer_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  gtc_timer #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  mon_ev;

  // monitor: pops one expected item per sample and compares
  always begin
    @(mon_ev);
    begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = it.is_irq ? {31'd0, irq} : rdata;
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_wr(input logic [7:0] a, input logic [31:0] d);
    wr(a, d); idle(LAT);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); addr = a;
    it.is_irq = 1'b0; it.a = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    #1 -> mon_ev;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.a = 8'hFF; it.exp = {31'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    #1 -> mon_ev;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a;
    #1 v = rdata;
  endtask

  // expected compare value under auto-step: smallest base+n*step >= v
  function automatic logic [31:0] next_cmp(input logic [31:0] base,
      input logic [31:0] st, input logic [31:0] v);
    logic [31:0] r = base;
    while (r < v) r = r + st;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, 32'h0, "R1 cnt lo");
    rd(8'h04, 32'h0, "R1 cnt hi");
    rd(8'h1C, 32'h0, "R1 ctrl");
    rd(8'h28, 32'h0, "R1 done bits");
    rd(8'h20, 32'h0, "R1 pending");
    chk_irq(1'b0, "R1 irq");

    // R2 write delay and done bit, R3 clear-on-write-1
    wr(8'h10, 32'h55);
    idle(2);
    rd(8'h28, 32'h0, "R2 done before delay");
    rd(8'h28, 32'h1, "R2 done at delay");
    rd(8'h10, 32'h55, "R2 cmp lo value");
    wr(8'h28, 32'h0);
    rd(8'h28, 32'h1, "R3 write 0 keeps");
    wr(8'h28, 32'h1);
    rd(8'h28, 32'h0, "R3 write 1 clears");

    // R4 load halves while stopped
    settle_wr(8'h00, 32'hFFFF_FFF0);
    settle_wr(8'h04, 32'h1);
    rd(8'h08, 32'h3, "R2 counter done bits");
    rd(8'h04, 32'h1, "R4 cnt hi");
    rd(8'h00, 32'hFFFF_FFF0, "R4 cnt lo");
    idle(3);
    rd(8'h00, 32'hFFFF_FFF0, "R4 held while stopped");

    // R5 running, carry into high word
    settle_wr(8'h1C, 32'h1);
    rd(8'h28, 32'h8, "R2 ctrl done bit");
    idle(30);
    rd(8'h04, 32'h2, "R5 carry into hi");
    peek(8'h00, v);
    rd(8'h00, v + 32'd1, "R5 read does not latch");
    peek(8'h00, v);
    idle(4);
    rd(8'h00, v + 32'd5, "R5 advance per cycle");

    // R6 single hit, R7 gating and clear, R9 immediate enable
    settle_wr(8'h1C, 32'h0);
    settle_wr(8'h00, 32'h0);
    settle_wr(8'h04, 32'h0);
    settle_wr(8'h10, 32'd20);
    wr(8'h24, 32'h1);
    rd(8'h24, 32'h1, "R9 enable immediate");
    wr(8'h1C, 32'h3);
    idle(LAT);
    rd(8'h20, 32'h0, "R6 no hit yet");
    idle(30);
    rd(8'h20, 32'h1, "R6 hit pends");
    chk_irq(1'b1, "R7 irq high");
    wr(8'h24, 32'h0);
    chk_irq(1'b0, "R7 irq gated off");
    rd(8'h20, 32'h1, "R7 pending kept while gated");
    wr(8'h24, 32'h1);
    chk_irq(1'b1, "R7 irq re-enabled");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h1, "R7 write 0 keeps pending");
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R7 write 1 clears pending");
    chk_irq(1'b0, "R7 irq low after clear");
    idle(40);
    rd(8'h20, 32'h0, "R6 no second hit");

    // R8 auto-step
    settle_wr(8'h1C, 32'h0);
    settle_wr(8'h00, 32'h0);
    settle_wr(8'h10, 32'd10);
    settle_wr(8'h18, 32'd16);
    rd(8'h18, 32'd16, "R8 step value");
    settle_wr(8'h1C, 32'h7);
    idle(100);
    peek(8'h00, v);
    rd(8'h10, next_cmp(32'd10, 32'd16, v + 32'd1), "R8 compare advanced");
    rd(8'h20, 32'h1, "R8 pending from periodic hit");
    wr(8'h20, 32'h1);
    idle(20);
    rd(8'h20, 32'h1, "R8 hit repeats");

    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule